// File: doc/BRIEF.md
# Conditional Relative Branch Resolver

This block decides the outcome of a conditional relative branch for an 8-bit processor with a 16-bit program counter. Each request carries the address of the branch instruction, an 8-bit signed displacement, a 3-bit condition code and the four status flags (carry, zero, overflow, negative). The block evaluates the condition, forms the fall-through and target addresses, and returns the next program counter and the number of cycles the branch costs.

The cost reflects a page penalty. A taken branch whose target lies in a different 256-byte page from the fall-through address takes one extra cycle. Results are registered and appear one clock after the request. They hold their value until the next request.

Top module: `branch_resolve`

## Requirements
- R1: While reset is asserted, and after it, until the first request, `rsp_valid` is 0 and `next_pc`, `cycle_cost`, `taken` and `page_cross` are all 0.
- R2: `rsp_valid` is 1 exactly in the cycle after a cycle in which `req_valid` was 1 at the clock edge; otherwise it is 0.
- R3: `cond_sel[2:1]` picks the tested flag: 00 = N, 01 = V, 10 = C, 11 = Z. `cond_sel[0]` gives the polarity: 1 branches when the flag is 1, and 0 branches when it is 0. `taken` reports the result.
- R4: When the branch is not taken, `next_pc` is `cur_pc + 2` modulo 65536, `cycle_cost` is 2 and `page_cross` is 0.
- R5: When the branch is taken, `next_pc` is `cur_pc + 2 + sext(disp)` modulo 65536, where `disp` is a two's-complement value from -128 to +127.
- R6: A taken branch whose target bits 15:8 equal the fall-through bits 15:8 has `cycle_cost` 3 and `page_cross` 0.
- R7: A taken branch whose target bits 15:8 differ from the fall-through bits 15:8 has `cycle_cost` 4 and `page_cross` 1.
- R8: In a cycle that follows a cycle with no request, `next_pc`, `cycle_cost`, `taken` and `page_cross` keep their previous values.
- R9: Address arithmetic wraps: a fall-through or target past 0xFFFF continues from 0x0000, and one below 0x0000 continues from 0xFFFF. The page check uses the wrapped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A branch is presented this cycle |
| cur_pc | input | 16 | Address of the branch instruction |
| disp | input | 8 | Signed displacement |
| cond_sel | input | 3 | Flag select [2:1] and polarity [0] |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_n | input | 1 | Negative flag |
| rsp_valid | output | 1 | Result registers were loaded at the last edge |
| next_pc | output | 16 | Resolved next program counter |
| cycle_cost | output | 3 | Cycles consumed by the branch (2, 3 or 4) |
| taken | output | 1 | Condition was met |
| page_cross | output | 1 | Taken branch crossed a 256-byte page |

## Verification
Every result lands exactly one clock edge after the request is sampled. The driver applies each request on a falling edge and pushes the expected item into a queue at that moment. The monitor samples one nanosecond after the following rising edge, so each popped item meets `rsp_valid` in the one cycle where it must be present. In a cycle with no request, the monitor instead checks that `rsp_valid` is low and that the outputs still equal the last result. Any response that arrives with no expected item waiting is reported as a failure.

// File: rtl/brx_pkg.sv
package brx_pkg;
  // Flag picked by cond_sel[2:1]
  typedef enum logic [1:0] {
    FLG_N = 2'b00,
    FLG_V = 2'b01,
    FLG_C = 2'b10,
    FLG_Z = 2'b11
  } flag_id_e;

  typedef struct packed {
    logic c;
    logic z;
    logic v;
    logic n;
  } flags_t;
endpackage

// File: rtl/brx_rst_sync.sv
module brx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/brx_cond_sel.sv
module brx_cond_sel
  import brx_pkg::*;
(
  input  logic [2:0] cond_sel,
  input  flags_t     flags,
  output logic       cond_met
);
  flag_id_e which;
  logic     flag_val;

  always_comb begin
    which = flag_id_e'(cond_sel[2:1]);
    unique case (which)
      FLG_N:   flag_val = flags.n;
      FLG_V:   flag_val = flags.v;
      FLG_C:   flag_val = flags.c;
      FLG_Z:   flag_val = flags.z;
      default: flag_val = 1'b0;
    endcase
    cond_met = (flag_val == cond_sel[0]);
  end
endmodule

// File: rtl/brx_target_calc.sv
module brx_target_calc #(
  parameter int PC_W     = 16,
  parameter int DISP_W   = 8,
  parameter int PAGE_LSB = 8,
  parameter int INSN_LEN = 2
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  output logic [PC_W-1:0]   fall_thru,
  output logic [PC_W-1:0]   target,
  output logic              crosses
);
  localparam int EXT_W = PC_W - DISP_W;

  logic [PC_W-1:0] disp_ext;

  always_comb begin
    disp_ext  = {{EXT_W{disp[DISP_W-1]}}, disp};
    fall_thru = pc + PC_W'(INSN_LEN);
    target    = fall_thru + disp_ext;
    crosses   = (fall_thru[PC_W-1:PAGE_LSB] != target[PC_W-1:PAGE_LSB]);
  end

  // The target is never more than one page away from the fall-through
  always_comb begin
    AST_ONE_PAGE_STEP: assert (!crosses ||
      (target[PC_W-1:PAGE_LSB] == fall_thru[PC_W-1:PAGE_LSB] + 1'b1) ||
      (target[PC_W-1:PAGE_LSB] == fall_thru[PC_W-1:PAGE_LSB] - 1'b1)); // R9
  end
endmodule

// File: rtl/brx_cost.sv
module brx_cost #(
  parameter int COST_W    = 3,
  parameter int BASE_COST = 2
) (
  input  logic              taken,
  input  logic              crosses,
  output logic [COST_W-1:0] cost
);
  localparam logic [COST_W-1:0] COST_NT    = COST_W'(BASE_COST);
  localparam logic [COST_W-1:0] COST_TK    = COST_W'(BASE_COST + 1);
  localparam logic [COST_W-1:0] COST_TK_PG = COST_W'(BASE_COST + 2);

  always_comb begin
    if (!taken)       cost = COST_NT;
    else if (crosses) cost = COST_TK_PG;
    else              cost = COST_TK;
  end
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import brx_pkg::*;
#(
  parameter int PC_W     = 16,
  parameter int DISP_W   = 8,
  parameter int PAGE_LSB = 8,
  parameter int INSN_LEN = 2,
  parameter int COST_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [DISP_W-1:0] disp,
  input  logic [2:0]        cond_sel,
  input  logic              flag_c,
  input  logic              flag_z,
  input  logic              flag_v,
  input  logic              flag_n,
  output logic              rsp_valid,
  output logic [PC_W-1:0]   next_pc,
  output logic [COST_W-1:0] cycle_cost,
  output logic              taken,
  output logic              page_cross
);
  logic              rst_sync_n;
  flags_t            flags;
  logic              cond_met;
  logic [PC_W-1:0]   fall_thru;
  logic [PC_W-1:0]   target;
  logic              crosses;
  logic              cross_eff;
  logic [COST_W-1:0] cost_d;
  logic [PC_W-1:0]   pc_d;

  logic              vld_q;
  logic [PC_W-1:0]   pc_q;
  logic [COST_W-1:0] cost_q;
  logic              tk_q;
  logic              pg_q;

  brx_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign flags = '{c: flag_c, z: flag_z, v: flag_v, n: flag_n};

  brx_cond_sel u_cond (
    .cond_sel (cond_sel),
    .flags    (flags),
    .cond_met (cond_met)
  );

  brx_target_calc #(
    .PC_W(PC_W), .DISP_W(DISP_W), .PAGE_LSB(PAGE_LSB), .INSN_LEN(INSN_LEN)
  ) u_calc (
    .pc        (cur_pc),
    .disp      (disp),
    .fall_thru (fall_thru),
    .target    (target),
    .crosses   (crosses)
  );

  assign cross_eff = cond_met & crosses;

  brx_cost #(.COST_W(COST_W), .BASE_COST(INSN_LEN)) u_cost (
    .taken   (cond_met),
    .crosses (cross_eff),
    .cost    (cost_d)
  );

  // Next-state selection
  always_comb begin
    pc_d = cond_met ? target : fall_thru;
  end

  // Valid flag: loads every cycle
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) vld_q <= 1'b0;
    else             vld_q <= req_valid;
  end

  // Result registers: load enabled by req_valid
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q   <= '0;
      cost_q <= '0;
      tk_q   <= 1'b0;
      pg_q   <= 1'b0;
    end else if (req_valid) begin
      pc_q   <= pc_d;
      cost_q <= cost_d;
      tk_q   <= cond_met;
      pg_q   <= cross_eff;
    end
  end

  assign rsp_valid  = vld_q;
  assign next_pc    = pc_q;
  assign cycle_cost = cost_q;
  assign taken      = tk_q;
  assign page_cross = pg_q;

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid); // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> !rsp_valid); // R2
  AST_NT_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> (taken || (next_pc == $past(cur_pc) + PC_W'(INSN_LEN)))); // R4
  AST_NT_COST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && !taken) |-> (cycle_cost == COST_W'(INSN_LEN) && !page_cross)); // R4
  AST_CROSS_NEEDS_TAKEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    page_cross |-> taken); // R7
  AST_TAKEN_COST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && taken) |-> (cycle_cost == COST_W'(INSN_LEN + 1) + COST_W'(page_cross))); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> ($stable(next_pc) && $stable(cycle_cost) && $stable(taken))); // R8
endmodule

// File: tb/branch_resolve_tb_top.sv
module branch_resolve_tb_top;
  typedef struct {
    logic [15:0] pc;
    logic [2:0]  cost;
    logic        tk;
    logic        pg;
    string       tag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [15:0] cur_pc;
  logic [7:0]  disp;
  logic [2:0]  cond_sel;
  logic        flag_c, flag_z, flag_v, flag_n;
  logic        rsp_valid;
  logic [15:0] next_pc;
  logic [2:0]  cycle_cost;
  logic        taken, page_cross;

  int   n_checks = 0;
  int   n_errs   = 0;
  exp_t sb_q[$];
  exp_t last_res;
  logic have_last = 1'b0;
  logic mon_on    = 1'b0;

  branch_resolve dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cur_pc(cur_pc),
    .disp(disp), .cond_sel(cond_sel), .flag_c(flag_c), .flag_z(flag_z),
    .flag_v(flag_v), .flag_n(flag_n), .rsp_valid(rsp_valid),
    .next_pc(next_pc), .cycle_cost(cycle_cost), .taken(taken),
    .page_cross(page_cross)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Reference model written from the requirements
  function automatic exp_t model(input logic [15:0] pc, input logic [7:0] d,
                                 input logic [2:0] sel, input logic [3:0] czvn,
                                 input string tag);
    exp_t e;
    logic f;
    logic [15:0] ft, tg;
    case (sel[2:1])
      2'b00: f = czvn[0];
      2'b01: f = czvn[1];
      2'b10: f = czvn[3];
      default: f = czvn[2];
    endcase
    e.tk = (f == sel[0]);
    ft = pc + 16'd2;
    tg = ft + {{8{d[7]}}, d};
    e.pc = e.tk ? tg : ft;
    e.pg = e.tk && (ft[15:8] != tg[15:8]);
    e.cost = !e.tk ? 3'd2 : (e.pg ? 3'd4 : 3'd3);
    e.tag = tag;
    return e;
  endfunction

  // czvn packs {c,z,v,n}
  task automatic drive(input logic [15:0] pc, input logic [7:0] d,
                       input logic [2:0] sel, input logic [3:0] czvn,
                       input string tag);
    @(negedge clk);
    req_valid = 1'b1; cur_pc = pc; disp = d; cond_sel = sel;
    {flag_c, flag_z, flag_v, flag_n} = czvn;
    sb_q.push_back(model(pc, d, sel, czvn, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: one ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      if (rsp_valid) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R2", "unexpected rsp_valid", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(next_pc == e.pc, e.tag, "next_pc", next_pc, e.pc);
          check(cycle_cost == e.cost, e.tag, "cycle_cost", cycle_cost, e.cost);
          check(taken == e.tk, e.tag, "taken", taken, e.tk);
          check(page_cross == e.pg, e.tag, "page_cross", page_cross, e.pg);
          last_res = e; have_last = 1'b1;
        end
      end else begin
        check(sb_q.size() == 0, "R2", "missing rsp_valid", 0, 1);
        if (have_last) begin
          check(next_pc == last_res.pc, "R8", "hold next_pc", next_pc, last_res.pc);
          check(cycle_cost == last_res.cost, "R8", "hold cost", cycle_cost, last_res.cost);
        end
      end
    end
  end

  initial begin
    #100000;
    check(1'b0, "WATCHDOG", "timeout", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; cur_pc = '0; disp = '0; cond_sel = '0;
    {flag_c, flag_z, flag_v, flag_n} = '0;
    repeat (3) @(negedge clk);
    check(rsp_valid == 0 && next_pc == 0 && cycle_cost == 0 && !taken && !page_cross,
          "R1", "outputs in reset", next_pc, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rsp_valid == 0 && next_pc == 0 && cycle_cost == 0,
          "R1", "outputs after reset", cycle_cost, 0);
    mon_on = 1'b1;

    // R3: all eight condition kinds, flags {c,z,v,n}
    drive(16'h1000, 8'h10, 3'b001, 4'b0001, "R3_n_set");
    drive(16'h1000, 8'h10, 3'b000, 4'b0001, "R3_n_clr");
    drive(16'h1000, 8'h10, 3'b011, 4'b0010, "R3_v_set");
    drive(16'h1000, 8'h10, 3'b010, 4'b1101, "R3_v_clr");
    drive(16'h1000, 8'h10, 3'b101, 4'b1000, "R3_c_set");
    drive(16'h1000, 8'h10, 3'b100, 4'b0111, "R3_c_clr");
    drive(16'h1000, 8'h10, 3'b111, 4'b0100, "R3_z_set");
    drive(16'h1000, 8'h10, 3'b110, 4'b1011, "R3_z_clr");
    idle(2);
    // R4: not taken
    drive(16'h20FE, 8'h40, 3'b101, 4'b0000, "R4_nt");
    // R5/R6: taken, same page
    drive(16'h2080, 8'h80, 3'b101, 4'b1000, "R5_R6_back128");
    drive(16'h2000, 8'h00, 3'b101, 4'b1000, "R6_zero_disp");
    drive(16'h2000, 8'h7F, 3'b101, 4'b1000, "R6_fwd127");
    // R7: crossings
    drive(16'h2080, 8'h7F, 3'b101, 4'b1000, "R7_fwd127_cross");
    drive(16'h2000, 8'hFC, 3'b101, 4'b1000, "R7_back_cross");
    drive(16'h20FE, 8'h00, 3'b101, 4'b1000, "R6_ft_new_page");
    idle(3);
    // R9: wrap
    drive(16'hFFFE, 8'h05, 3'b100, 4'b1000, "R9_nt_wrap");
    drive(16'hFFF0, 8'h7F, 3'b101, 4'b1000, "R9_tk_wrap_up");
    drive(16'h0000, 8'h80, 3'b101, 4'b1000, "R9_tk_wrap_down");
    drive(16'hFFFF, 8'hFF, 3'b111, 4'b0100, "R9_ft_wrap");
    idle(4);
    check(sb_q.size() == 0, "R2", "queue drained", sb_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule